// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges seven reset causes into a single core reset. The causes are an asynchronous power-on event, a low-supply indication from a voltage monitor, an active-low external reset pin, a missing-clock timeout, a comparator output, a watchdog expiry and a software request. The analog sensing, the comparator and the watchdog counter sit outside the block and arrive here as digital levels or pulses. The block also drives an open-drain pull-down on the external reset pin. After power-on it holds the core in reset for a programmable delay.

An 8-bit register port lets software arm three of the sources: the supply monitor, the missing-clock detector and the comparator. It also lets software request a reset. A read of the same register returns a one-hot record of the cause of the last reset. The supply-monitor enable is sticky: only a power-on event clears it. The block also issues a divide-by-12 tick that clocks the external watchdog. This tick restarts after every reset.

Top module: `sys_reset_ctrl`

## Requirements
- R1: While `rst_ni` is low, and for exactly POR_DELAY+1 cycles after it rises, `core_rst_o` and `pin_pull_o` are high. Afterwards the register reads 0x02, with bit 1 as the power/supply flag.
- R2: A power-on event disables the supply monitor. With the monitor disabled, `supply_low_i` has no effect.
- R3: Writing a 1 to bit 1 enables the supply monitor. Writing a 0 to bit 1 has no effect. Only a power-on event clears the enable, so it stays set across software and other resets.
- R4: While the monitor is enabled and the supply is low, the core is in reset and `pin_pull_o` is high. Each input passes through a two-flop synchroniser, so the reset begins on the third clock edge after the input changes. The reset ends on the third clock edge after the supply recovers, with no power-on delay, and bit 1 then reads 1. Enabling the monitor while the supply is already low starts a reset on the next clock.
- R5: A low level on `ext_rst_ni` resets the core without `pin_pull_o`. Bit 0 reads 1 after release. The block ignores the low level that its own pull-down causes on the pin.
- R6: Bit 2 enables the missing-clock source. When the source is enabled and `clk_missing_i` is high, the core is held in reset and bit 2 then reads 1. When the source is disabled, the input is ignored.
- R7: Bit 5 enables the comparator source. When the source is enabled and `cmp_below_i` is high, the core is held in reset and bit 5 then reads 1.
- R8: Missing-clock, comparator, watchdog and software resets never assert `pin_pull_o`.
- R9: A rising edge on `wdt_expire_i` gives a one-cycle core reset, and bit 3 then reads 1.
- R10: Writing a 1 to bit 4 outside reset gives a one-cycle core reset on the next clock, and bit 4 then reads 1.
- R11: `wdt_tick_o` pulses once every 12 cycles. The first pulse comes in the 12th cycle after reset release.
- R12: After any reset exactly one flag reads 1. When causes are simultaneous, the priority is supply, then pin, then missing clock, then comparator, then watchdog, then software.
- R13: Every reset clears the missing-clock and comparator enables. Register writes made while the core is in reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on event, active low |
| supply_low_i | input | 1 | Supply below threshold |
| ext_rst_ni | input | 1 | Sensed level of the external reset pin, active low |
| clk_missing_i | input | 1 | Missing-clock timeout |
| cmp_below_i | input | 1 | Comparator: non-inverting input below inverting input |
| wdt_expire_i | input | 1 | Watchdog expiry |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Reset cause flags |
| core_rst_o | output | 1 | Core reset, active high |
| pin_pull_o | output | 1 | Pull the external reset pin low |
| wdt_tick_o | output | 1 | Watchdog clock enable, one pulse per 12 cycles |

## Verification
A cause can arrive in the same clock as another cause. The bench provokes this in two ways. First, it times a software reset write to land on exactly the edge where a watchdog pulse emerges from the synchroniser and the edge detector; the result must be a single one-cycle reset whose flag names the watchdog. Second, it sweeps all fifteen combinations of the four level sources asserted together and compares the flag with the priority order and the pin pull-down with the presence of the supply cause. The pin is looped back through the pull-down, which shows that the block's own pull on the pin is never taken for an external reset.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  localparam int REG_W = 8;
  localparam int B_PIN = 0;
  localparam int B_PWR = 1;
  localparam int B_MCD = 2;
  localparam int B_WDT = 3;
  localparam int B_SW  = 4;
  localparam int B_CMP = 5;

  typedef enum logic [1:0] {ST_POR, ST_RUN, ST_HOLD} seq_st_e;
  typedef enum logic [2:0] {C_POR, C_SUPPLY, C_PIN, C_MCD, C_CMP, C_WDT, C_SW} cause_e;

  function automatic logic [REG_W-1:0] cause_flag(cause_e c);
    logic [REG_W-1:0] f;
    f = '0;
    case (c)
      C_POR, C_SUPPLY: f[B_PWR] = 1'b1;
      C_PIN:           f[B_PIN] = 1'b1;
      C_MCD:           f[B_MCD] = 1'b1;
      C_CMP:           f[B_CMP] = 1'b1;
      C_WDT:           f[B_WDT] = 1'b1;
      default:         f[B_SW]  = 1'b1;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/rst_sync_bank.sv
module rst_sync_bank #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/rst_cfg_regs.sv
module rst_cfg_regs
  import rst_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             run_i,
  input  logic             rel_i,
  input  cause_e           rel_cause_i,
  output logic             mon_en_o,
  output logic             mcd_en_o,
  output logic             cmp_en_o,
  output logic             sw_req_o,
  output logic [REG_W-1:0] rdata_o
);
  logic             mon_en_q, mcd_en_q, cmp_en_q;
  logic [REG_W-1:0] flags_q;
  logic             wr_ok;

  assign wr_ok = we_i && run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_en_q <= 1'b0;
      mcd_en_q <= 1'b0;
      cmp_en_q <= 1'b0;
      flags_q  <= cause_flag(C_POR);
    end else if (rel_i) begin
      flags_q  <= cause_flag(rel_cause_i);
      mcd_en_q <= 1'b0;
      cmp_en_q <= 1'b0;
    end else if (wr_ok) begin
      if (wdata_i[B_PWR]) mon_en_q <= 1'b1;
      mcd_en_q <= wdata_i[B_MCD];
      cmp_en_q <= wdata_i[B_CMP];
    end
  end

  assign mon_en_o = mon_en_q;
  assign mcd_en_o = mcd_en_q;
  assign cmp_en_o = cmp_en_q;
  assign sw_req_o = wr_ok && wdata_i[B_SW];
  assign rdata_o  = flags_q;

  a_r3_mon_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_en_q |=> mon_en_q);
  a_r12_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(flags_q));
  a_r13_en_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |=> (!mcd_en_q && !cmp_en_q));
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_ctrl_pkg::*;
#(
  parameter int POR_DELAY = 4096,
  parameter int BLANK     = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   supply_low_i,
  input  logic   pin_low_i,
  input  logic   mcd_i,
  input  logic   cmp_i,
  input  logic   wdt_i,
  input  logic   sw_req_i,
  input  logic   mon_en_i,
  input  logic   mcd_en_i,
  input  logic   cmp_en_i,
  output logic   core_rst_o,
  output logic   pin_pull_o,
  output logic   rel_o,
  output cause_e rel_cause_o
);
  localparam int CW = (POR_DELAY > 1) ? $clog2(POR_DELAY) : 1;
  localparam int BW = $clog2(BLANK + 1);

  seq_st_e       state_q, state_d;
  cause_e        cause_q, cause_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] blank_q;
  logic [1:0]    por_q;
  logic          wdt_prev_q;

  logic   supply_act, pin_act, mcd_act, cmp_act, wdt_evt;
  logic   lvl_any, evt_any, rel;
  cause_e lvl_cause, evt_cause;

  assign pin_pull_o = (state_q == ST_POR) || (state_q == ST_HOLD && cause_q == C_SUPPLY);
  assign core_rst_o = (state_q != ST_RUN);

  assign supply_act = supply_low_i && mon_en_i;
  // own pull-down echoes on the pin: masked while pulling and during sync flush
  assign pin_act    = pin_low_i && (blank_q == '0) && !pin_pull_o;
  assign mcd_act    = mcd_i && mcd_en_i;
  assign cmp_act    = cmp_i && cmp_en_i;
  assign wdt_evt    = wdt_i && !wdt_prev_q;

  always_comb begin
    lvl_any   = supply_act || pin_act || mcd_act || cmp_act;
    lvl_cause = supply_act ? C_SUPPLY : pin_act ? C_PIN : mcd_act ? C_MCD : C_CMP;
    evt_any   = lvl_any || wdt_evt || sw_req_i;
    evt_cause = lvl_any ? lvl_cause : wdt_evt ? C_WDT : C_SW;
    state_d   = state_q;
    cause_d   = cause_q;
    cnt_d     = cnt_q;
    rel       = 1'b0;
    unique case (state_q)
      ST_POR: begin
        if (por_q[1]) begin
          if (cnt_q == CW'(POR_DELAY - 1)) begin
            state_d = ST_RUN;
            cause_d = C_POR;
            rel     = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (evt_any) begin
          state_d = ST_HOLD;
          cause_d = evt_cause;
        end
      end
      ST_HOLD: begin
        if (lvl_any) begin
          cause_d = lvl_cause;
        end else begin
          state_d = ST_RUN;
          rel     = 1'b1;
        end
      end
      default: state_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_POR;
      cause_q    <= C_POR;
      cnt_q      <= '0;
      por_q      <= '0;
      wdt_prev_q <= 1'b0;
      blank_q    <= BW'(BLANK);
    end else begin
      state_q    <= state_d;
      cause_q    <= cause_d;
      cnt_q      <= cnt_d;
      por_q      <= {por_q[0], 1'b1};
      wdt_prev_q <= wdt_i;
      if (pin_pull_o)          blank_q <= BW'(BLANK);
      else if (blank_q != '0)  blank_q <= blank_q - 1'b1;
    end
  end

  assign rel_o       = rel;
  assign rel_cause_o = cause_q;

  a_r1_por_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POR && !por_q[1]) |=> core_rst_o);
  a_r4_supply_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_o && supply_act) |=> (core_rst_o && pin_pull_o));
  a_r8_no_pull_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_o && !lvl_any && (wdt_evt || sw_req_i)) |=> !pin_pull_o);
endmodule

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic core_rst_i,
  output logic tick_o
);
  localparam int DW = $clog2(DIV);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (core_rst_i)               cnt_q <= '0;
    else if (cnt_q == DW'(DIV - 1))    cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !core_rst_i && (cnt_q == DW'(DIV - 1));

  a_r11_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sys_reset_ctrl.sv
module sys_reset_ctrl
  import rst_ctrl_pkg::*;
#(
  parameter int POR_DELAY   = 4096,
  parameter int SYNC_STAGES = 2,
  parameter int WDT_DIV     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_low_i,
  input  logic             ext_rst_ni,
  input  logic             clk_missing_i,
  input  logic             cmp_below_i,
  input  logic             wdt_expire_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             core_rst_o,
  output logic             pin_pull_o,
  output logic             wdt_tick_o
);
  localparam int NSRC = 5;

  logic [NSRC-1:0] raw, syn;
  logic   mon_en, mcd_en, cmp_en, sw_req, rel;
  cause_e rel_cause;

  assign raw = {!ext_rst_ni, supply_low_i, clk_missing_i, cmp_below_i, wdt_expire_i};

  rst_sync_bank #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  rst_seq #(.POR_DELAY(POR_DELAY), .BLANK(SYNC_STAGES + 1)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_low_i(syn[3]),
    .pin_low_i   (syn[4]),
    .mcd_i       (syn[2]),
    .cmp_i       (syn[1]),
    .wdt_i       (syn[0]),
    .sw_req_i    (sw_req),
    .mon_en_i    (mon_en),
    .mcd_en_i    (mcd_en),
    .cmp_en_i    (cmp_en),
    .core_rst_o  (core_rst_o),
    .pin_pull_o  (pin_pull_o),
    .rel_o       (rel),
    .rel_cause_o (rel_cause)
  );

  rst_cfg_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .run_i      (!core_rst_o),
    .rel_i      (rel),
    .rel_cause_i(rel_cause),
    .mon_en_o   (mon_en),
    .mcd_en_o   (mcd_en),
    .cmp_en_o   (cmp_en),
    .sw_req_o   (sw_req),
    .rdata_o    (reg_rdata_o)
  );

  wdt_tick_div #(.DIV(WDT_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .core_rst_i(core_rst_o),
    .tick_o    (wdt_tick_o)
  );

  a_r10_sw_enters_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_o && reg_we_i && reg_wdata_i[B_SW]) |=> core_rst_o);
endmodule

// File: tb/sys_reset_ctrl_tb_top.sv
module sys_reset_ctrl_tb_top;
  localparam int POR = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_low = 1'b0, pin_drv_n = 1'b1, clk_missing = 1'b0;
  logic       cmp_below = 1'b0, wdt_exp = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       core_rst, pin_pull, tick, ext_n;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  // pin loopback: the block's own pull-down is seen on the sensed pin
  assign ext_n = pin_drv_n & ~pin_pull;

  sys_reset_ctrl #(.POR_DELAY(POR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .supply_low_i(supply_low), .ext_rst_ni(ext_n),
    .clk_missing_i(clk_missing), .cmp_below_i(cmp_below), .wdt_expire_i(wdt_exp),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .core_rst_o(core_rst), .pin_pull_o(pin_pull), .wdt_tick_o(tick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1; wdata = d;
    cyc(1);
    we = 1'b0; wdata = '0;
  endtask

  task automatic wait_low(output int k);
    k = 0;
    while (core_rst && k < 200) begin cyc(1); k++; end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int k, j;
    logic [7:0] exp_f;
    cyc(3);
    chk("R1 core_rst in por", core_rst, 1);
    chk("R1 pin pull in por", pin_pull, 1);
    chk("R1 flags in por", rdata, 8'h02);
    rst_n = 1'b1;
    k = 0; cyc(1);
    while (core_rst && k < 1000) begin k++; cyc(1); end
    chk("R1 por delay length", k, POR + 1);
    chk("R1 flags after por", rdata, 8'h02);

    supply_low = 1'b1; cyc(6);
    chk("R2 monitor disabled after por", core_rst, 0);
    wr(8'h02);
    chk("R3 enable write not yet reset", core_rst, 0);
    cyc(1);
    chk("R4 enable while low resets", core_rst, 1);
    chk("R4 supply pulls pin", pin_pull, 1);
    supply_low = 1'b0; cyc(2);
    chk("R4 held until sync", core_rst, 1);
    cyc(1);
    chk("R4 release without por delay", core_rst, 0);
    chk("R4 flag", rdata, 8'h02);

    wr(8'h10);
    chk("R10 sw reset asserted", core_rst, 1);
    chk("R8 sw no pull", pin_pull, 0);
    cyc(1);
    chk("R10 sw one cycle", core_rst, 0);
    chk("R10 sw flag", rdata, 8'h10);

    supply_low = 1'b1; cyc(3);
    chk("R3 monitor survives sw reset", core_rst, 1);
    supply_low = 1'b0; wait_low(k);
    chk("R4 flag again", rdata, 8'h02);

    k = 1;
    while (!tick && k < 50) begin cyc(1); k++; end
    chk("R11 first tick", k, 12);
    cyc(1); j = 1;
    while (!tick && j < 50) begin cyc(1); j++; end
    chk("R11 tick period", j, 12);

    pin_drv_n = 1'b0; cyc(3);
    chk("R5 pin reset", core_rst, 1);
    chk("R5 no pull on pin reset", pin_pull, 0);
    pin_drv_n = 1'b1; cyc(2);
    chk("R5 held until sync", core_rst, 1);
    cyc(1);
    chk("R5 released", core_rst, 0);
    chk("R5 flag", rdata, 8'h01);

    clk_missing = 1'b1; cyc(5);
    chk("R6 disabled source ignored", core_rst, 0);
    chk("R6 flags unchanged", rdata, 8'h01);
    clk_missing = 1'b0; cyc(3);
    wr(8'h04);
    clk_missing = 1'b1; cyc(3);
    chk("R6 missing clock reset", core_rst, 1);
    chk("R8 mcd no pull", pin_pull, 0);
    clk_missing = 1'b0; wait_low(k);
    chk("R6 flag", rdata, 8'h04);
    clk_missing = 1'b1; cyc(5);
    chk("R13 mcd enable cleared by reset", core_rst, 0);
    clk_missing = 1'b0; cyc(3);

    wr(8'h20);
    cmp_below = 1'b1; cyc(3);
    chk("R7 comparator reset", core_rst, 1);
    chk("R8 cmp no pull", pin_pull, 0);
    cmp_below = 1'b0; wait_low(k);
    chk("R7 flag", rdata, 8'h20);
    cmp_below = 1'b1; cyc(5);
    chk("R13 cmp enable cleared by reset", core_rst, 0);
    cmp_below = 1'b0; cyc(3);

    wdt_exp = 1'b1; cyc(1); wdt_exp = 1'b0; cyc(1);
    chk("R9 wdt not yet", core_rst, 0);
    cyc(1);
    chk("R9 wdt reset", core_rst, 1);
    chk("R8 wdt no pull", pin_pull, 0);
    cyc(1);
    chk("R9 wdt one cycle", core_rst, 0);
    chk("R9 flag", rdata, 8'h08);

    wdt_exp = 1'b1; cyc(1); wdt_exp = 1'b0; cyc(1);
    wr(8'h10);
    chk("R12 simultaneous wdt and sw reset", core_rst, 1);
    cyc(1);
    chk("R12 simultaneous single cycle", core_rst, 0);
    chk("R12 wdt beats sw", rdata, 8'h08);

    pin_drv_n = 1'b0; cyc(3);
    wr(8'h04);
    pin_drv_n = 1'b1; wait_low(k);
    clk_missing = 1'b1; cyc(5);
    chk("R13 write during reset ignored", core_rst, 0);
    chk("R13 flags after pin", rdata, 8'h01);
    clk_missing = 1'b0; cyc(3);

    for (int m = 1; m < 16; m++) begin
      wr(8'h26); cyc(2);
      supply_low = m[0]; pin_drv_n = !m[1]; clk_missing = m[2]; cmp_below = m[3];
      cyc(3);
      chk($sformatf("R12 sweep %0d reset", m), core_rst, 1);
      chk($sformatf("R8 sweep %0d pull", m), pin_pull, m[0]);
      supply_low = 1'b0; pin_drv_n = 1'b1; clk_missing = 1'b0; cmp_below = 1'b0;
      wait_low(k);
      chk($sformatf("R4 sweep %0d release latency", m), k, 3);
      exp_f = m[0] ? 8'h02 : m[1] ? 8'h01 : m[2] ? 8'h04 : 8'h20;
      chk($sformatf("R12 sweep %0d flag", m), rdata, exp_f);
      cyc(4);
    end

    rst_n = 1'b0; cyc(2); rst_n = 1'b1;
    wait_low(k);
    supply_low = 1'b1; cyc(5);
    chk("R2 monitor cleared by por", core_rst, 0);
    chk("R1 flags after second por", rdata, 8'h02);
    supply_low = 1'b0; cyc(2);
    finish_run();
  end
endmodule